// File: doc/BRIEF.md
# Interlocked Parallel Channel Device Controller

This block sits on the device side of a byte-wide parallel I/O interface shared by a channel and several control units. Nothing on the interface has a fixed timing relationship to the device clock. Each transfer is paced by tag lines that the two sides raise and lower in turn. The outbound tags mark what the channel has placed on its bus: an address, a command, or a service reply. The outbound side also carries a select line. The inbound tags mark what the device has placed on its own bus: its address, a status byte, or a request for service. Both buses carry eight data bits and one odd-parity bit.

A local service request starts a sequence. The device raises its address tag with its own address on the inbound bus and waits for the channel's command tag. It lowers the address tag when the command tag arrives. When the command tag falls, the device reads the outbound bus. An all-zero byte means proceed, and any other value ends the sequence. To proceed, the device fetches a fixed number of data bytes, each through a four-phase service handshake. It then presents a status byte, which the channel accepts with one more service handshake.

The channel can also select a device. It raises select together with the address tag and an address on the bus. A device that is idle and whose address does not match passes select on to the next device in the chain. A device whose address matches keeps select and answers with its address tag. Every outbound tag passes through a two-flop synchronizer before the state machine sees it.

Top module: `chan_dev_ctrl`

## Requirements
- R1: During reset and on the first cycle after it, all three inbound tags are low, the inbound bus is 0x00 with parity 1, the pass-on select is low, and no byte is reported.
- R2: When the local request is high while idle, the device raises its address tag on the next clock edge and drives DEV_ADDR (default 0x5A) on the inbound bus. At most one inbound tag is ever high at a time.
- R3: The address tag drops once the command tag is seen. When the command tag is later seen low and the outbound bus is 0x00, the service tag rises.
- R4: If the outbound bus is nonzero when the command tag is seen low, the device returns to idle without raising any further tag.
- R5: The service tag stays high until the service-out tag is seen. On that edge the device captures the byte, pulses the received-valid output for one cycle with the byte, and drops the service tag. The service tag rises again only after service-out is seen low.
- R6: Exactly NBYTES (default 3) data bytes are taken per sequence. After the last service-out falls, the status tag is raised.
- R7: While the status tag is high, the inbound bus carries 0x0C, with bit 0 set when any data byte in that sequence had bad parity. The status tag drops once service-out is seen, and the device goes idle once service-out is seen low.
- R8: Parity is odd on both buses: the nine bits hold an odd number of ones. The parity-error output pulses together with received-valid for a data byte whose nine bits hold an even count, and the inbound parity bit always makes its bus odd.
- R9: While idle, the pass-on select follows the synchronized select input, except when the synchronized address tag is also high and the outbound bus equals DEV_ADDR. In that case pass-on stays low and the device raises its address tag.
- R10: The pass-on select is low whenever the device is in a sequence, even if select is high.
- R11: A change on an outbound tag changes the device's tag outputs on the third rising edge after it: two synchronizer stages plus the state register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low reset |
| svc_req | input | 1 | Local request for a service sequence (synchronous) |
| ch_bus | input | 8 | Outbound data bus from the channel |
| ch_bus_par | input | 1 | Odd parity bit of ch_bus |
| ch_addr_tag | input | 1 | Channel marks an address on its bus |
| ch_cmd_tag | input | 1 | Channel command tag |
| ch_svc_tag | input | 1 | Channel service reply tag |
| ch_sel_tag | input | 1 | Select arriving from the channel or the previous device |
| dev_bus | output | 8 | Inbound data bus to the channel |
| dev_bus_par | output | 1 | Odd parity bit of dev_bus |
| dev_addr_tag | output | 1 | Device address on the inbound bus |
| dev_stat_tag | output | 1 | Device status on the inbound bus |
| dev_svc_tag | output | 1 | Device requests a data byte |
| sel_pass | output | 1 | Select passed on to the next device |
| rx_data | output | 8 | Last data byte received |
| rx_valid | output | 1 | One-cycle pulse when rx_data is new |
| par_err | output | 1 | Pulses with rx_valid when the byte's parity is bad |

## Verification
Because of the synchronizers, every reaction to an outbound tag is due on the third rising edge after the bench changes that tag. A local request takes effect one edge later, and select pass-on follows two edges after select changes. The bench changes inputs only just after a falling edge. Its reference model advances one step per rising edge and compares all outputs at the next falling edge, so each result is checked in the cycle it is due. Directed checks also count the exact edges around a command-tag change and watch the idle window after a stop byte.

// File: rtl/chan_dev_ctrl.sv
module chan_dev_ctrl #(
  parameter logic [7:0] DEV_ADDR  = 8'h5A,
  parameter int         NBYTES    = 3,
  parameter logic [7:0] STAT_BASE = 8'h0C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       svc_req,
  input  logic [7:0] ch_bus,
  input  logic       ch_bus_par,
  input  logic       ch_addr_tag,
  input  logic       ch_cmd_tag,
  input  logic       ch_svc_tag,
  input  logic       ch_sel_tag,
  output logic [7:0] dev_bus,
  output logic       dev_bus_par,
  output logic       dev_addr_tag,
  output logic       dev_stat_tag,
  output logic       dev_svc_tag,
  output logic       sel_pass,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       par_err
);
  localparam int CW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam logic [CW-1:0] LAST = CW'(NBYTES - 1);

  typedef enum logic [2:0] {IDLE, ADDR, CMDF, SVC, SVF, STA, STF} st_t;
  st_t state;

  logic [3:0] s1, s2;
  logic [CW-1:0] cnt;
  logic err;

  wire addr_s = s2[0];
  wire cmd_s  = s2[1];
  wire svc_s  = s2[2];
  wire sel_s  = s2[3];
  wire hit    = addr_s && (ch_bus == DEV_ADDR);
  wire bad    = ~^{ch_bus, ch_bus_par};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= {ch_sel_tag, ch_svc_tag, ch_cmd_tag, ch_addr_tag};
      s2 <= s1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state    <= IDLE;
      cnt      <= '0;
      err      <= 1'b0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      par_err  <= 1'b0;
      case (state)
        IDLE: if (svc_req || (sel_s && hit)) state <= ADDR;
        ADDR: if (cmd_s) state <= CMDF;
        CMDF: if (!cmd_s) begin
          if (ch_bus == 8'h00) begin
            state <= SVC;
            cnt   <= '0;
            err   <= 1'b0;
          end else state <= IDLE;
        end
        SVC: if (svc_s) begin
          rx_data  <= ch_bus;
          rx_valid <= 1'b1;
          par_err  <= bad;
          if (bad) err <= 1'b1;
          state <= SVF;
        end
        SVF: if (!svc_s) begin
          if (cnt == LAST) state <= STA;
          else begin
            cnt   <= cnt + 1'b1;
            state <= SVC;
          end
        end
        STA: if (svc_s) state <= STF;
        STF: if (!svc_s) state <= IDLE;
        default: state <= IDLE;
      endcase
    end

  assign dev_addr_tag = (state == ADDR);
  assign dev_svc_tag  = (state == SVC);
  assign dev_stat_tag = (state == STA);
  assign dev_bus      = dev_addr_tag ? DEV_ADDR :
                        dev_stat_tag ? (STAT_BASE | {7'b0, err}) : 8'h00;
  assign dev_bus_par  = ~^dev_bus;
  assign sel_pass     = sel_s && (state == IDLE) && !hit;

  assert_one_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dev_addr_tag, dev_svc_tag, dev_stat_tag}));
  assert_addr_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_addr_tag) |-> $past(cmd_s) || $past(!ch_cmd_tag) == 1'b0 || $past(cmd_s));
  assert_byte_on_svc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(dev_svc_tag) && !dev_svc_tag);
  assert_stat_after_svf_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_stat_tag) |-> $past(!svc_s));
  assert_perr_with_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
    par_err |-> rx_valid);
  assert_no_pass_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pass |-> !dev_addr_tag && !dev_svc_tag && !dev_stat_tag);
endmodule

// File: tb/chan_dev_ctrl_tb.sv
module chan_dev_ctrl_tb;
  localparam logic [7:0] ADR = 8'h5A;
  localparam int N = 3;

  logic clk = 0, rst_n = 0, svc_req = 0;
  logic [7:0] ch_bus = 0;
  logic ch_bus_par = 1, ch_addr_tag = 0, ch_cmd_tag = 0, ch_svc_tag = 0, ch_sel_tag = 0;
  logic [7:0] dev_bus, rx_data;
  logic dev_bus_par, dev_addr_tag, dev_stat_tag, dev_svc_tag, sel_pass, rx_valid, par_err;

  always #4 clk = ~clk;

  chan_dev_ctrl u_dut (.*);

  int vectors = 0, fails = 0, cyc = 0;
  logic [7:0] exp_q[$];

  int ms = 0, mcnt = 0;
  logic merr = 0, mrxv = 0, mpe = 0;
  logic [7:0] mrxd = 0;
  logic [3:0] m1 = 0, m2 = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic op(input logic [7:0] b);
    return ~^b;
  endfunction

  task automatic model_step();
    logic adr2, cmd2, svc2, sel2;
    int ns;
    adr2 = m2[0]; cmd2 = m2[1]; svc2 = m2[2]; sel2 = m2[3];
    ns = ms;
    mrxv = 0; mpe = 0;
    case (ms)
      0: if (svc_req || (sel2 && adr2 && ch_bus == ADR)) ns = 1;
      1: if (cmd2) ns = 2;
      2: if (!cmd2) begin
           if (ch_bus == 0) begin ns = 3; mcnt = 0; merr = 0; end
           else ns = 0;
         end
      3: if (svc2) begin
           mrxv = 1; mrxd = ch_bus;
           mpe = ((^{ch_bus, ch_bus_par}) == 1'b0);
           if (mpe) merr = 1;
           ns = 4;
         end
      4: if (!svc2) begin
           if (mcnt == N - 1) ns = 5;
           else begin mcnt++; ns = 3; end
         end
      5: if (svc2) ns = 6;
      6: if (!svc2) ns = 0;
      default: ns = 0;
    endcase
    ms = ns;
    m2 = m1;
    m1 = {ch_sel_tag, ch_svc_tag, ch_cmd_tag, ch_addr_tag};
  endtask

  task automatic compare();
    logic [7:0] eb;
    eb = (ms == 1) ? ADR : (ms == 5) ? (8'h0C | {7'b0, merr}) : 8'h00;
    chk("R2", "dev_addr_tag", dev_addr_tag, ms == 1);
    chk("R5", "dev_svc_tag", dev_svc_tag, ms == 3);
    chk("R6", "dev_stat_tag", dev_stat_tag, ms == 5);
    chk("R7", "dev_bus", dev_bus, eb);
    chk("R8", "dev_bus_par", dev_bus_par, op(eb));
    chk("R9", "sel_pass", sel_pass, m2[3] && ms == 0 && !(m2[0] && ch_bus == ADR));
    chk("R5", "rx_valid", rx_valid, mrxv);
    if (mrxv) chk("R5", "rx_data", rx_data, mrxd);
    chk("R8", "par_err", par_err, mpe);
    if (rx_valid) begin
      if (exp_q.size() == 0) chk("R6", "unexpected byte", 1, 0);
      else chk("R5", "byte order", rx_data, exp_q.pop_front());
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
    model_step();
    compare();
    if (cyc > 20000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  task automatic wait_out(input int which, input logic val);
    logic v;
    for (int i = 0; i < 200; i++) begin
      v = (which == 0) ? dev_addr_tag : (which == 1) ? dev_svc_tag : dev_stat_tag;
      if (v == val) return;
      tick();
    end
    chk("R11", "tag wait timeout", 1, 0);
  endtask

  task automatic drive_bus(input logic [7:0] b, input logic good);
    ch_bus = b;
    ch_bus_par = good ? op(b) : ~op(b);
  endtask

  task automatic run_seq(input logic [7:0] stopb, input int bad_i, input logic [7:0] base);
    wait_out(0, 1);
    ch_cmd_tag = 1;
    tick(); tick();
    chk("R11", "addr tag held 2 edges", dev_addr_tag, 1);
    tick();
    chk("R3", "addr tag drops on cmd", dev_addr_tag, 0);
    drive_bus(stopb, 1);
    ch_cmd_tag = 0;
    if (stopb != 0) begin
      for (int i = 0; i < 8; i++) begin
        tick();
        chk("R4", "no tag after stop", {dev_addr_tag, dev_svc_tag, dev_stat_tag}, 0);
      end
      drive_bus(0, 1);
      return;
    end
    wait_out(1, 1);
    chk("R3", "svc tag after proceed", dev_svc_tag, 1);
    for (int i = 0; i < N; i++) begin
      if (i > 0) wait_out(1, 1);
      drive_bus(base + 8'(i), i != bad_i);
      exp_q.push_back(base + 8'(i));
      ch_svc_tag = 1;
      wait_out(1, 0);
      drive_bus(0, 1);
      tick(); tick();
      chk("R5", "svc tag waits for svc-out fall", dev_svc_tag, 0);
      ch_svc_tag = 0;
    end
    wait_out(2, 1);
    chk("R7", "status byte", dev_bus, (bad_i >= 0) ? 8'h0D : 8'h0C);
    ch_svc_tag = 1;
    wait_out(2, 0);
    ch_svc_tag = 0;
    for (int i = 0; i < 4; i++) tick();
    chk("R6", "idle after status", {dev_addr_tag, dev_svc_tag, dev_stat_tag}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "reset tags", {dev_addr_tag, dev_svc_tag, dev_stat_tag, sel_pass, rx_valid}, 0);
    chk("R1", "reset bus", {dev_bus, dev_bus_par}, 9'h001);
    rst_n = 1;
    tick();
    chk("R1", "post-reset tags", {dev_addr_tag, dev_svc_tag, dev_stat_tag}, 0);

    svc_req = 1; tick(); svc_req = 0;
    chk("R2", "addr tag on request", dev_addr_tag, 1);
    chk("R2", "own address on bus", dev_bus, ADR);
    run_seq(8'h00, -1, 8'h31);

    svc_req = 1; tick(); svc_req = 0;
    run_seq(8'h00, 1, 8'hC4);

    svc_req = 1; tick(); svc_req = 0;
    run_seq(8'h40, -1, 8'h00);

    drive_bus(8'h11, 1); ch_addr_tag = 1; ch_sel_tag = 1;
    tick(); tick();
    chk("R9", "select passed on mismatch", sel_pass, 1);
    ch_sel_tag = 0; ch_addr_tag = 0;
    tick(); tick();
    chk("R9", "pass follows select low", sel_pass, 0);

    drive_bus(ADR, 1); ch_addr_tag = 1; ch_sel_tag = 1;
    tick(); tick();
    chk("R9", "select kept on match", sel_pass, 0);
    tick();
    chk("R9", "selected device answers", dev_addr_tag, 1);
    ch_addr_tag = 0;
    drive_bus(0, 1);
    run_seq(8'h00, -1, 8'h70);
    ch_sel_tag = 0;
    for (int i = 0; i < 3; i++) tick();

    svc_req = 1; tick(); svc_req = 0;
    ch_sel_tag = 1;
    tick(); tick(); tick();
    chk("R10", "no pass while busy", sel_pass, 0);
    run_seq(8'h00, 2, 8'hA0);
    ch_sel_tag = 0;
    for (int i = 0; i < 4; i++) tick();

    chk("R6", "all bytes consumed", exp_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule